// File: doc/BRIEF.md
# Host Soft-Reset Generator with Power-Up Hold-Off

This block drives an active-low soft-reset line toward a host processor from an embedded controller. Firmware can assert and release the line directly through a command input. The line is also the OR of that command and a hardware hold-off request.

The hardware path covers a host that starts an LPC cycle while the controller is still in its own power-up reset. Such an access would otherwise be ignored. When both option inputs are set and the LPC link is not powered down, that transaction arms a hold that keeps the host in reset. The hold lasts for the rest of the power-up reset and for a fixed number of clock cycles after it ends. A further qualified transaction during that extension restarts the count. The LPC decoder that produces the transaction strobe is outside this block.

Top module: `hrg_host_rst_gen`

## Requirements
- R1: With the firmware command low and no hardware hold pending, `hostRstN` is 1. Power-up reset on its own does not pull it low.
- R2: `swHostRst` = 1 drives `hostRstN` to 0 in the same cycle, with no register in the path. Returning it to 0 releases the line when no hardware hold is pending.
- R3: A qualified `lpcTxnSeen` sampled at a clock edge while `pwrUpRst` = 1 drives `hostRstN` to 0 from the next cycle. It stays 0 for as long as `pwrUpRst` remains 1.
- R4: A transaction is qualified only when `rstOnPorEn` = 1, `lpcTmoEn` = 1 and `lpcPwrDown` = 0 all hold together. Any other transaction leaves `hostRstN` unchanged.
- R5: Once `pwrUpRst` falls, a pending hold keeps `hostRstN` at 0 for exactly `EXT_CYCLES` clock cycles. The line then returns to 1.
- R6: A qualified transaction sampled at an edge during the extension reloads the count. `hostRstN` then stays 0 for `EXT_CYCLES` cycles after that edge.
- R7: A transaction while `pwrUpRst` = 0 and no hold is pending has no effect on `hostRstN`.
- R8: The two sources combine as an OR. Releasing the firmware command during a hold keeps the line low. Ending the hold while the command is 1 also keeps the line low.
- R9: `rstN` = 0 clears any pending hold asynchronously. With the command low, `hostRstN` then reads 1 without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Asynchronous active-low reset of this clock domain |
| pwrUpRst | input | 1 | High while the controller power-up reset is active |
| swHostRst | input | 1 | Firmware host-reset command, 1 = hold host in reset |
| rstOnPorEn | input | 1 | Option: enable the hardware hold-off during power-up reset |
| lpcTmoEn | input | 1 | Option: second enable that qualifies the hardware path |
| lpcTxnSeen | input | 1 | One-cycle strobe, an LPC transaction was detected |
| lpcPwrDown | input | 1 | High while the LPC link is powered down |
| hostRstN | output | 1 | Active-low host soft-reset output |

## Verification
The bench builds the block with `EXT_CYCLES` = 6. This gives a 3-bit counter that passes through every value, including the reload and terminal-count boundaries, within a few cycles. With a window this short, each sample of the extension can be checked exactly: the length after release, the length after a reload in the middle of the window, and the interaction with the firmware command at both ends of the window. The same small value lets every gating combination and the asynchronous clear be exercised back to back.

// File: rtl/hrg_pkg.sv
package hrg_pkg;

  // Strobes from the trigger control to the extension datapath.
  typedef struct packed {
    logic arm;     // first qualified transaction during power-up reset
    logic reload;  // pending hold: restart window (power-up reset or new transaction)
    logic tick;    // pending hold after release: consume one cycle of the window
  } hrgStrobes_t;

  function automatic int unsigned cntWidth(input int unsigned cycles);
    return (cycles < 2) ? 1 : $clog2(cycles + 1);
  endfunction

endpackage

// File: rtl/hrg_trigger.sv
module hrg_trigger
  import hrg_pkg::*;
(
  input  logic        pwrUpRst,
  input  logic        rstOnPorEn,
  input  logic        lpcTmoEn,
  input  logic        lpcTxnSeen,
  input  logic        lpcPwrDown,
  input  logic        holdQ,
  output hrgStrobes_t strobes
);

  logic qualTxn;

  always_comb begin
    qualTxn        = lpcTxnSeen & rstOnPorEn & lpcTmoEn & ~lpcPwrDown;
    strobes.arm    = pwrUpRst & qualTxn & ~holdQ;
    strobes.reload = holdQ & (pwrUpRst | qualTxn);
    strobes.tick   = holdQ & ~pwrUpRst & ~qualTxn;
  end

endmodule

// File: rtl/hrg_extend.sv
module hrg_extend
  import hrg_pkg::*;
#(
  parameter int unsigned EXT_CYCLES = 16,
  localparam int unsigned CNT_W = cntWidth(EXT_CYCLES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  hrgStrobes_t      strobes,
  output logic             holdQ,
  output logic [CNT_W-1:0] cntQ
);

  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(EXT_CYCLES);
  localparam logic [CNT_W-1:0] ONE_VAL  = CNT_W'(1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdQ <= 1'b0;
      cntQ  <= '0;
    end else if (strobes.arm || strobes.reload) begin
      holdQ <= 1'b1;
      cntQ  <= LOAD_VAL;
    end else if (strobes.tick) begin
      if (cntQ <= ONE_VAL) begin
        holdQ <= 1'b0;
        cntQ  <= '0;
      end else begin
        cntQ <= cntQ - ONE_VAL;
      end
    end
  end

endmodule

// File: rtl/hrg_host_rst_gen.sv
module hrg_host_rst_gen
  import hrg_pkg::*;
#(
  parameter int unsigned EXT_CYCLES = 16
) (
  input  logic clk,
  input  logic rstN,
  input  logic pwrUpRst,
  input  logic swHostRst,
  input  logic rstOnPorEn,
  input  logic lpcTmoEn,
  input  logic lpcTxnSeen,
  input  logic lpcPwrDown,
  output logic hostRstN
);

  localparam int unsigned CNT_W = cntWidth(EXT_CYCLES);

  hrgStrobes_t      strobes;
  logic             holdQ;
  logic [CNT_W-1:0] cntQ;

  hrg_trigger trigger_i (
    .pwrUpRst   (pwrUpRst),
    .rstOnPorEn (rstOnPorEn),
    .lpcTmoEn   (lpcTmoEn),
    .lpcTxnSeen (lpcTxnSeen),
    .lpcPwrDown (lpcPwrDown),
    .holdQ      (holdQ),
    .strobes    (strobes)
  );

  hrg_extend #(.EXT_CYCLES(EXT_CYCLES)) extend_i (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .holdQ   (holdQ),
    .cntQ    (cntQ)
  );

  // Firmware path is combinational; hardware path comes from the hold register.
  assign hostRstN = ~(swHostRst | holdQ);

endmodule

// File: rtl/hrg_checker.sv
module hrg_checker
  import hrg_pkg::*;
#(
  parameter int unsigned EXT_CYCLES = 16,
  localparam int unsigned CNT_W = cntWidth(EXT_CYCLES)
) (
  input logic             clk,
  input logic             rstN,
  input logic             pwrUpRst,
  input logic             swHostRst,
  input logic             rstOnPorEn,
  input logic             lpcTmoEn,
  input logic             lpcTxnSeen,
  input logic             lpcPwrDown,
  input logic             hostRstN,
  input logic             holdQ,
  input logic [CNT_W-1:0] cntQ
);

  logic qual;
  assign qual = lpcTxnSeen && rstOnPorEn && lpcTmoEn && !lpcPwrDown;

  assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rstN)
    (!swHostRst && !holdQ) |-> hostRstN);

  assert_sw_low_R2: assert property (@(posedge clk) disable iff (!rstN)
    swHostRst |-> !hostRstN);

  assert_arm_R3: assert property (@(posedge clk) disable iff (!rstN)
    (pwrUpRst && qual) |=> !hostRstN);

  assert_por_keeps_R3: assert property (@(posedge clk) disable iff (!rstN)
    (holdQ && pwrUpRst) |=> holdQ);

  assert_unqual_ignored_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!holdQ && !qual) |=> !holdQ);

  assert_window_runs_R5: assert property (@(posedge clk) disable iff (!rstN)
    (holdQ && !pwrUpRst && cntQ > CNT_W'(1)) |=> holdQ);

  assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (!rstN)
    cntQ <= CNT_W'(EXT_CYCLES));

  assert_reload_R6: assert property (@(posedge clk) disable iff (!rstN)
    (holdQ && qual) |=> (holdQ && cntQ == CNT_W'(EXT_CYCLES)));

  assert_no_por_no_arm_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!holdQ && !pwrUpRst) |=> !holdQ);

endmodule

bind hrg_host_rst_gen hrg_checker #(.EXT_CYCLES(EXT_CYCLES)) chk_i (.*);

// File: tb/hrg_host_rst_gen_tb.sv
`timescale 1ns/1ps
module hrg_host_rst_gen_tb_top;

  localparam int N = 6;

  logic clk = 1'b0;
  logic rstN, pwrUpRst, swHostRst, rstOnPorEn, lpcTmoEn, lpcTxnSeen, lpcPwrDown;
  logic hostRstN;

  int nVec = 0;
  int nBad = 0;
  bit doneFlag = 0;

  hrg_host_rst_gen #(.EXT_CYCLES(N)) dut_i (
    .clk(clk), .rstN(rstN), .pwrUpRst(pwrUpRst), .swHostRst(swHostRst),
    .rstOnPorEn(rstOnPorEn), .lpcTmoEn(lpcTmoEn), .lpcTxnSeen(lpcTxnSeen),
    .lpcPwrDown(lpcPwrDown), .hostRstN(hostRstN)
  );

  always #5 clk = ~clk;

  task automatic check(input int act, input int exp, input string req);
    nVec++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    if (!doneFlag) begin
      doneFlag = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  endtask

  task automatic applyReset();
    @(negedge clk);
    rstN = 0; pwrUpRst = 0; swHostRst = 0; rstOnPorEn = 0;
    lpcTmoEn = 0; lpcTxnSeen = 0; lpcPwrDown = 0;
    @(negedge clk); #1;
    check(hostRstN, 1, "R1 reset state");
    @(negedge clk); rstN = 1;
  endtask

  // Count consecutive low samples, one per cycle, starting now (negedge + 1).
  task automatic measureLow(input int reloadAt, output int n);
    n = 0;
    while (!hostRstN && n < 200) begin
      n++;
      if (n == reloadAt) lpcTxnSeen = 1;
      @(negedge clk);
      lpcTxnSeen = 0;
      #1;
    end
  endtask

  // Enable options, enter power-up reset, send one qualified transaction.
  task automatic armDuringPor();
    @(negedge clk);
    rstOnPorEn = 1; lpcTmoEn = 1; lpcPwrDown = 0; pwrUpRst = 1;
    #1 check(hostRstN, 1, "R1 power-up reset alone");
    @(negedge clk); lpcTxnSeen = 1;
    @(negedge clk); lpcTxnSeen = 0; #1;
    check(hostRstN, 0, "R3 armed next cycle");
  endtask

  task automatic testSw();
    applyReset();
    repeat (3) @(negedge clk);
    #1 check(hostRstN, 1, "R1 idle");
    swHostRst = 1; #1;
    check(hostRstN, 0, "R2 sw assert same cycle");
    @(negedge clk); #1 check(hostRstN, 0, "R2 sw held");
    swHostRst = 0; #1;
    check(hostRstN, 1, "R2 sw release");
  endtask

  task automatic testExtend();
    int n;
    applyReset();
    armDuringPor();
    repeat (9) @(negedge clk);
    #1 check(hostRstN, 0, "R3 held through power-up reset");
    @(negedge clk); pwrUpRst = 0; #1;
    measureLow(0, n);
    check(n, N, "R5 extension length");
    check(hostRstN, 1, "R5 released after window");
  endtask

  task automatic testRestart();
    int n;
    applyReset();
    armDuringPor();
    @(negedge clk); pwrUpRst = 0; #1;
    measureLow(3, n);
    check(n, N + 3, "R6 restart length");
  endtask

  task automatic testGate(input logic pd, input logic tmo, input logic por, input string tag);
    applyReset();
    @(negedge clk);
    rstOnPorEn = por; lpcTmoEn = tmo; lpcPwrDown = pd; pwrUpRst = 1;
    @(negedge clk); lpcTxnSeen = 1;
    @(negedge clk); lpcTxnSeen = 0; #1;
    check(hostRstN, 1, tag);
    @(negedge clk); pwrUpRst = 0; #1;
    check(hostRstN, 1, tag);
  endtask

  task automatic testNoPor();
    applyReset();
    @(negedge clk); rstOnPorEn = 1; lpcTmoEn = 1; lpcTxnSeen = 1;
    @(negedge clk); lpcTxnSeen = 0; #1;
    check(hostRstN, 1, "R7 txn outside power-up reset");
    repeat (N) @(negedge clk);
    #1 check(hostRstN, 1, "R7 still released");
  endtask

  task automatic testOr();
    int n;
    // Command held across end of window.
    applyReset();
    armDuringPor();
    swHostRst = 1;
    @(negedge clk); pwrUpRst = 0;
    repeat (N + 2) @(negedge clk);
    #1 check(hostRstN, 0, "R8 sw holds after window");
    swHostRst = 0; #1;
    check(hostRstN, 1, "R8 release after window");
    // Command released during window.
    applyReset();
    armDuringPor();
    @(negedge clk); pwrUpRst = 0; swHostRst = 1;
    @(negedge clk); swHostRst = 0; #1;
    check(hostRstN, 0, "R8 hold survives sw release");
    measureLow(0, n);
    check(n, N - 1, "R8 remaining window");
  endtask

  task automatic testAsync();
    applyReset();
    armDuringPor();
    #2 rstN = 0; #1;
    check(hostRstN, 1, "R9 async clear");
    @(negedge clk); pwrUpRst = 0; rstN = 1;
    @(negedge clk); #1 check(hostRstN, 1, "R9 stays clear");
  endtask

  initial begin
    rstN = 0; pwrUpRst = 0; swHostRst = 0; rstOnPorEn = 0;
    lpcTmoEn = 0; lpcTxnSeen = 0; lpcPwrDown = 0;
    testSw();
    testExtend();
    testRestart();
    testGate(1'b1, 1'b1, 1'b1, "R4 link powered down");
    testGate(1'b0, 1'b0, 1'b1, "R4 timeout option off");
    testGate(1'b0, 1'b1, 1'b0, "R4 power-up option off");
    testNoPor();
    testOr();
    testAsync();
    summary();
  end

  initial begin
    repeat (20000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog: actual running expected finished");
    summary();
  end

endmodule